// File: doc/BRIEF.md
# Serial Word Clock Burst Generator

This block sits behind an FSK demodulator. It takes the recovered asynchronous bit stream and a carrier-present qualifier, and it drives three signals for an external shift register and a microcontroller. The first is the serial data, gated so that it rests high without carrier. The second is a low-going data clock that pulses once per data bit, with its rising edge at the centre of each bit. The third is a ready strobe that drops once the eighth bit has been clocked.

All bit timing comes from dividing the master clock by an integer. The default of 2976 gives about 1202.8 bit/s from a 3.5795 MHz oscillator. A falling edge on the gated line, seen while the block is idle, is treated as a candidate start bit. The line is checked again at the half-bit point. If it is still low, the word is clocked out: a burst of eight pulses with none during the start or stop bit, and the ready strobe follows. If it has gone high again, the edge is dropped as a glitch. A power-down input stops the word and parks all outputs high.

Top module: `wordclk_gen`

## Requirements
- R1: `ser_out` equals `demod_in` one clock later while `carrier_ok` is 1 and `pwdn` is 0. While `carrier_ok` is 0, `ser_out` is 1 on the following clock, whatever `demod_in` does.
- R2: A start is detected when, in idle, the gated line is 0 while `ser_out` is still 1. The line is sampled again HALF = DIV/2 clocks later. A 1 there abandons the word: no data clock pulses and no ready strobe. A 0 there confirms the word.
- R3: `dclk_n` idles at 1. Each confirmed word gives exactly BITS low-going pulses on `dclk_n`.
- R4: If the start is detected at clock edge t0, the k-th rising edge of `dclk_n` (k = 1..BITS) falls at edge t0 + HALF + k*DIV. Each pulse is low for exactly HALF clocks.
- R5: `dclk_n` stays 1 for the whole start bit and for the whole stop bit.
- R6: `dready_n` goes from 1 to 0 on the same clock edge as the BITS-th rising edge of `dclk_n`.
- R7: `dready_n` returns to 1 after DIV clocks, or on the edge where the next start is detected if that comes first.
- R8: While `pwdn` is 1, `ser_out`, `dclk_n` and `dready_n` are 1 from the next clock onward, and any word in progress is abandoned. A word begun after `pwdn` is released is clocked out completely.
- R9: While `rst_n` is 0, all three outputs are 1, and this takes effect without waiting for a clock.
- R10: Data bits are sent least significant first, with mark = 1 and space = 0. Sampling `ser_out` at each `dclk_n` rising edge rebuilds the transmitted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pwdn | input | 1 | Power-down, active high; parks all outputs high |
| carrier_ok | input | 1 | Carrier-present qualifier, active high |
| demod_in | input | 1 | Recovered serial bits from the demodulator (mark = 1) |
| ser_out | output | 1 | Gated serial data, registered |
| dclk_n | output | 1 | Low-going data clock burst, idles high |
| dready_n | output | 1 | Active-low byte-ready strobe |

## Verification
The bench builds the block with DIV = 16 and BITS = 8, so a bit lasts 16 clocks and the half-bit resample point sits 8 clocks after the start edge. At that scale, every rising edge of every burst can be checked against its exact cycle offset within a few thousand cycles. Start pulses of HALF-2 and HALF+1 clocks fall on either side of the resample point. A stop bit of only 4 clocks makes the next start arrive before the ready window has run out, so the early-release case of R7 is reached as well.

// File: rtl/wordclk_pkg.sv
package wordclk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } wc_state_e;

endpackage

// File: rtl/wordclk_gate.sv
// Carrier gating of the serial line, the registered data output and
// falling-edge detection on the gated line.
module wordclk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pwdn,
  input  logic carrier_ok,
  input  logic demod_in,
  output logic line_lvl,
  output logic start_fall,
  output logic ser_out
);

  logic ser_q;
  logic ser_d;

  assign line_lvl   = carrier_ok ? demod_in : 1'b1;
  assign ser_d      = pwdn | line_lvl;
  assign start_fall = ser_q & ~line_lvl & ~pwdn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q <= 1'b1;
    end else begin
      ser_q <= ser_d;
    end
  end

  assign ser_out = ser_q;

endmodule

// File: rtl/wordclk_seq.sv
// Word sequencer: start qualification at half bit, bit timing and the
// data clock burst.
module wordclk_seq
  import wordclk_pkg::*;
#(
  parameter int DIV  = 2976,
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwdn,
  input  logic start_fall,
  input  logic line_lvl,
  output logic start_seen,
  output logic word_done,
  output logic dclk_n
);

  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);
  localparam int BW   = $clog2(BITS);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(HALF - 1);
  localparam logic [CW-1:0] CNT_LOW  = CW'(DIV - HALF);
  localparam logic [BW-1:0] BIT_LAST = BW'(BITS - 1);

  wc_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic            dclk_n_q;
  logic            dclk_low_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    bit_d      = bit_q;
    start_seen = 1'b0;
    word_done  = 1'b0;
    if (pwdn) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      bit_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_fall) begin
            state_d    = ST_START;
            cnt_d      = '0;
            start_seen = 1'b1;
          end
        end
        ST_START: begin
          if (cnt_q == CNT_MID) begin
            cnt_d = '0;
            bit_d = '0;
            state_d = line_lvl ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
            if (bit_q == BIT_LAST) begin
              state_d   = ST_IDLE;
              bit_d     = '0;
              word_done = 1'b1;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          bit_d   = '0;
        end
      endcase
    end
    dclk_low_d = (state_d == ST_DATA) && (cnt_d >= CNT_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      bit_q    <= '0;
      dclk_n_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      bit_q    <= bit_d;
      dclk_n_q <= ~dclk_low_d;
    end
  end

  assign dclk_n = dclk_n_q;

endmodule

// File: rtl/wordclk_ready.sv
// Byte-ready strobe: low from the last data clock edge until one bit
// period has passed or the next start is seen.
module wordclk_ready #(
  parameter int DIV = 2976
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwdn,
  input  logic word_done,
  input  logic start_seen,
  output logic dready_n
);

  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] RDY_LAST = CW'(DIV - 1);

  logic          rdy_n_q, rdy_n_d;
  logic [CW-1:0] rcnt_q, rcnt_d;

  always_comb begin
    rdy_n_d = rdy_n_q;
    rcnt_d  = rcnt_q;
    if (pwdn) begin
      rdy_n_d = 1'b1;
      rcnt_d  = '0;
    end else if (word_done) begin
      rdy_n_d = 1'b0;
      rcnt_d  = '0;
    end else if (!rdy_n_q) begin
      if (start_seen || (rcnt_q == RDY_LAST)) begin
        rdy_n_d = 1'b1;
        rcnt_d  = '0;
      end else begin
        rcnt_d = rcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_n_q <= 1'b1;
      rcnt_q  <= '0;
    end else begin
      rdy_n_q <= rdy_n_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign dready_n = rdy_n_q;

endmodule

// File: rtl/wordclk_gen.sv
module wordclk_gen #(
  parameter int DIV  = 2976,
  parameter int BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwdn,
  input  logic carrier_ok,
  input  logic demod_in,
  output logic ser_out,
  output logic dclk_n,
  output logic dready_n
);

  logic line_lvl;
  logic start_fall;
  logic start_seen;
  logic word_done;

  wordclk_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwdn       (pwdn),
    .carrier_ok (carrier_ok),
    .demod_in   (demod_in),
    .line_lvl   (line_lvl),
    .start_fall (start_fall),
    .ser_out    (ser_out)
  );

  wordclk_seq #(
    .DIV  (DIV),
    .BITS (BITS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwdn       (pwdn),
    .start_fall (start_fall),
    .line_lvl   (line_lvl),
    .start_seen (start_seen),
    .word_done  (word_done),
    .dclk_n     (dclk_n)
  );

  wordclk_ready #(
    .DIV (DIV)
  ) u_ready (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwdn       (pwdn),
    .word_done  (word_done),
    .start_seen (start_seen),
    .dready_n   (dready_n)
  );

endmodule

// File: rtl/wordclk_chk.sv
module wordclk_chk #(
  parameter int DIV = 2976
) (
  input logic clk,
  input logic rst_n,
  input logic pwdn,
  input logic carrier_ok,
  input logic ser_out,
  input logic dclk_n,
  input logic dready_n
);

  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV) + 1;

  logic [CW-1:0] dlo_run;
  logic [CW-1:0] rlo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlo_run <= '0;
      rlo_run <= '0;
    end else begin
      dlo_run <= dclk_n   ? '0 : dlo_run + 1'b1;
      rlo_run <= dready_n ? '0 : rlo_run + 1'b1;
    end
  end

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !carrier_ok |=> ser_out);

  p_pwdn_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwdn |=> (ser_out && dclk_n && dready_n));

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dclk_n) && !$past(pwdn)) |-> (dlo_run == CW'(HALF)));

  p_ready_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dready_n) |-> $rose(dclk_n));

  p_ready_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rlo_run <= CW'(DIV));

endmodule

bind wordclk_gen wordclk_chk #(.DIV(DIV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwdn       (pwdn),
  .carrier_ok (carrier_ok),
  .ser_out    (ser_out),
  .dclk_n     (dclk_n),
  .dready_n   (dready_n)
);

// File: tb/wordclk_gen_tb.sv
module wordclk_gen_tb;

  localparam int DIV  = 16;
  localparam int HALF = DIV / 2;
  localparam int BITS = 8;

  logic clk;
  logic rst_n;
  logic pwdn;
  logic carrier_ok;
  logic demod_in;
  logic ser_out;
  logic dclk_n;
  logic dready_n;

  int nchecks = 0;
  int nfail   = 0;
  int cyc     = 0;
  int word_s  = 0;
  int rise_cnt = 0;
  int lowsamp  = 0;
  int rdy_fall_cyc = -1;
  int rdy_rise_cyc = -1;
  int rdy_falls    = 0;
  int fall_pulses  = -1;
  int rise_at_start = -1;
  logic [7:0] cap = '0;
  bit   ign = 1'b0;
  logic dclk_prev = 1'b1;
  logic rdy_prev  = 1'b1;

  wordclk_gen #(.DIV(DIV), .BITS(BITS)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwdn       (pwdn),
    .carrier_ok (carrier_ok),
    .demod_in   (demod_in),
    .ser_out    (ser_out),
    .dclk_n     (dclk_n),
    .dready_n   (dready_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (!ign && rst_n) begin
      if (!dclk_prev && dclk_n) begin
        rise_cnt++;
        cap = {ser_out, cap[7:1]};
        check(cyc - word_s == HALF + rise_cnt * DIV, "R4 rise timing",
              cyc - word_s, HALF + rise_cnt * DIV);
      end
      if (!dclk_n) lowsamp++;
      if (rdy_prev && !dready_n) begin
        rdy_fall_cyc = cyc;
        fall_pulses  = rise_cnt;
        rdy_falls++;
      end
      if (!rdy_prev && dready_n) rdy_rise_cyc = cyc;
    end
    dclk_prev = dclk_n;
    rdy_prev  = dready_n;
  end

  task automatic hold(input logic v, input int n);
    demod_in = v;
    repeat (n) @(negedge clk);
  endtask

  // One full word, LSB first; called at a negedge with the line high.
  task automatic send_word(input logic [7:0] d, input int stop_len, input bit chk_rdy);
    int bad_start;
    int bad_stop;
    bad_start = 0;
    bad_stop  = 0;
    word_s = cyc + 1;
    rise_cnt = 0;
    lowsamp = 0;
    cap = '0;
    rdy_fall_cyc = -1;
    fall_pulses = -1;
    demod_in = 1'b0;
    @(negedge clk);
    check(ser_out == 1'b0, "R1 ser_out follows line", ser_out, 0);
    for (int i = 0; i < DIV - 1; i++) begin
      if (!dclk_n) bad_start++;
      @(negedge clk);
    end
    rise_at_start = rdy_rise_cyc;
    for (int b = 0; b < 8; b++) hold(d[b], DIV);
    demod_in = 1'b1;
    for (int j = 0; j < stop_len; j++) begin
      if (!dclk_n) bad_stop++;
      @(negedge clk);
    end
    check(bad_start == 0, "R5 no pulse in start bit", bad_start, 0);
    check(bad_stop == 0, "R5 no pulse in stop bit", bad_stop, 0);
    check(rise_cnt == BITS, "R3 pulses per word", rise_cnt, BITS);
    check(lowsamp == BITS * HALF, "R4 total low time", lowsamp, BITS * HALF);
    check(cap == d, "R10 rebuilt byte", cap, d);
    check(fall_pulses == BITS, "R6 ready after last pulse", fall_pulses, BITS);
    check(rdy_fall_cyc - word_s == HALF + BITS * DIV, "R6 ready edge",
          rdy_fall_cyc - word_s, HALF + BITS * DIV);
    if (chk_rdy)
      check(rdy_rise_cyc - rdy_fall_cyc == DIV, "R7 ready window",
            rdy_rise_cyc - rdy_fall_cyc, DIV);
  endtask

  task automatic t_reset_state;
    check(ser_out == 1'b1, "R9 ser_out in reset", ser_out, 1);
    check(dclk_n == 1'b1, "R9 dclk_n in reset", dclk_n, 1);
    check(dready_n == 1'b1, "R9 dready_n in reset", dready_n, 1);
  endtask

  task automatic t_words;
    send_word(8'hA5, 2 * DIV, 1'b1);
    send_word(8'h3C, 2 * DIV, 1'b1);
    send_word(8'h00, 2 * DIV, 1'b1);
    send_word(8'hFF, 2 * DIV, 1'b1);
    send_word(8'h81, 2 * DIV, 1'b1);
  endtask

  task automatic t_carrier_off;
    int bad;
    int rf;
    bad = 0;
    rf = rdy_falls;
    rise_cnt = 0;
    carrier_ok = 1'b0;
    for (int k = 0; k < 6; k++) begin
      demod_in = k[0];
      for (int i = 0; i < DIV; i++) begin
        @(negedge clk);
        if (!ser_out) bad++;
      end
    end
    demod_in = 1'b1;
    @(negedge clk);
    carrier_ok = 1'b1;
    repeat (2) @(negedge clk);
    check(bad == 0, "R1 ser_out held high without carrier", bad, 0);
    check(rise_cnt == 0, "R3 no burst without carrier", rise_cnt, 0);
    check(rdy_falls == rf, "R6 no ready without carrier", rdy_falls, rf);
  endtask

  task automatic t_glitch;
    int rf;
    rf = rdy_falls;
    rise_cnt = 0;
    word_s = cyc + 1;
    hold(1'b0, HALF - 2);
    hold(1'b1, 3 * DIV);
    check(rise_cnt == 0, "R2 short low aborted", rise_cnt, 0);
    check(rdy_falls == rf, "R2 no ready after glitch", rdy_falls, rf);
    // Low just past the resample point confirms a start; line then stays high.
    rise_cnt = 0;
    cap = '0;
    word_s = cyc + 1;
    hold(1'b0, HALF + 1);
    hold(1'b1, 10 * DIV);
    check(rise_cnt == BITS, "R2 start confirmed at half bit", rise_cnt, BITS);
    check(cap == 8'hFF, "R10 all-mark byte", cap, 8'hFF);
  endtask

  task automatic t_short_stop;
    int f;
    send_word(8'h5A, 4, 1'b0);
    f = rdy_fall_cyc;
    send_word(8'hC3, 2 * DIV, 1'b1);
    check(rise_at_start - f == DIV + 4 - HALF, "R7 early release at next start",
          rise_at_start - f, DIV + 4 - HALF);
  endtask

  task automatic t_pwdn;
    ign = 1'b1;
    hold(1'b0, DIV);
    hold(1'b1, DIV);
    hold(1'b0, HALF + 2);
    pwdn = 1'b1;
    @(negedge clk);
    check(ser_out == 1'b1, "R8 ser_out parked", ser_out, 1);
    check(dclk_n == 1'b1, "R8 dclk_n parked", dclk_n, 1);
    check(dready_n == 1'b1, "R8 dready_n parked", dready_n, 1);
    hold(1'b0, 2 * DIV);
    check(ser_out == 1'b1, "R8 ser_out high in power-down", ser_out, 1);
    check(dclk_n == 1'b1, "R8 no clock in power-down", dclk_n, 1);
    demod_in = 1'b1;
    @(negedge clk);
    pwdn = 1'b0;
    hold(1'b1, DIV);
    ign = 1'b0;
    send_word(8'h96, 2 * DIV, 1'b1);
  endtask

  task automatic t_async_reset;
    ign = 1'b1;
    hold(1'b0, DIV);
    hold(1'b0, DIV);
    hold(1'b1, HALF + 3);
    rst_n = 1'b0;
    #1;
    t_reset_state();
    @(negedge clk);
    demod_in = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    hold(1'b1, DIV);
    ign = 1'b0;
    send_word(8'h69, 2 * DIV, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    pwdn = 1'b0;
    carrier_ok = 1'b1;
    demod_in = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_words();
    t_carrier_off();
    t_glitch();
    t_short_stop();
    t_pwdn();
    t_async_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchecks++;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

endmodule